// File: doc/BRIEF.md
# Dual-Select Static RAM with Pin-Level Control

This block is a word-organised static memory behind a classic asynchronous-memory pin set. It has an address bus, two chip selects of opposite polarity (an active-low select and an active-high enable), an active-low write strobe and an active-low output enable. The bidirectional data bus is split into a data-in bus, a data-out bus and a drive-enable, so that the pad ring or a tristate wrapper can rebuild the real pin. A system clock samples every control pin. The sampled pins choose one of four modes: deselect, read, write or output-disable.

A write is open only while the active-low select is low, the active-high enable is high and the write strobe is low. Any of the three can end the write, and the word and address captured last before the window closes are committed. A read drives the addressed word on the second rising clock edge after the pins settle. It keeps following the address for as long as the read controls stay active. The width of the array is a parameter. With `ADDR_W` = 13 and `DATA_W` = 8 it is the 8192 x 8 organisation.

Top module: `dsram_top`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (8192 x 8 with ADDR_W=13). A word written at any address, including address 0 and the highest address, reads back unchanged.
- R2: While `csn_i` is high, `dq_oe_o` is 0, `dq_o` is 0 and no word is written, whatever the other controls are.
- R3: While `ce_i` is low, `dq_oe_o` is 0, `dq_o` is 0 and no word is written, whatever the other controls are.
- R4: With `csn_i`=0, `ce_i`=1, `wen_i`=1 and `oen_i`=0 held at a rising edge, the word at `addr_i` appears on `dq_o` with `dq_oe_o`=1 after the next rising edge (a latency of two edges). A new address on each cycle gives a new word on each cycle.
- R5: With `csn_i`=0, `ce_i`=1 and `wen_i`=0, the bus is not driven (`dq_oe_o`=0) for either value of `oen_i`, and the write takes effect.
- R6: With `csn_i`=0, `ce_i`=1, `wen_i`=1 and `oen_i`=1, the bus is not driven and no access takes place.
- R7: The write window is the overlap of `csn_i` low, `ce_i` high and `wen_i` low. Raising `wen_i`, raising `csn_i` or lowering `ce_i` each closes the window and commits the word.
- R8: When address or data change inside one window, only the last sampled address and data are stored. An address that was presented earlier in the same window keeps its old content.
- R9: A read that is sampled on the same edge as a write commit returns the committed word if the addresses match, and the stored word if they differ.
- R10: Contents are kept through any number of deselect and output-disable cycles.
- R11: During reset and after it, `dq_oe_o`=0 and `dq_o`=0, and no write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; samples all pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| csn_i | input | 1 | Chip select, active low |
| ce_i | input | 1 | Chip enable, active high |
| wen_i | input | 1 | Write strobe, active low |
| oen_i | input | 1 | Output enable, active low |
| dq_i | input | DATA_W | Data bus, inbound half |
| dq_o | output | DATA_W | Data bus, outbound half (0 when not driven) |
| dq_oe_o | output | 1 | Drive enable for the data bus |

## Verification
A write commit and a read can land on the same clock edge. This happens when the write is closed by raising `wen_i` while `oen_i` is already low, so the same sample that closes the window also starts a read. The bench provokes this with a matching address and expects the newly committed word on `dq_o`. It then repeats the case with a different address and expects that address's older content. In both cases `dq_o` is sampled two edges after the closing pins are applied.

// File: rtl/dsram_pkg.sv
package dsram_pkg;
  typedef enum logic [1:0] {
    MODE_DESEL = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_ODIS  = 2'd3
  } mode_e;

  function automatic mode_e decode_mode(logic csn, logic ce, logic wen, logic oen);
    if (csn || !ce) return MODE_DESEL;
    if (!wen)       return MODE_WRITE;
    if (!oen)       return MODE_READ;
    return MODE_ODIS;
  endfunction
endpackage

// File: rtl/dsram_sampler.sv
module dsram_sampler #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              csn_i,
  input  logic              ce_i,
  input  logic              wen_i,
  input  logic              oen_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              csn_o,
  output logic              ce_o,
  output logic              wen_o,
  output logic              oen_o,
  output logic [DATA_W-1:0] din_o
);
  // reset to a deselected pin state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      csn_o  <= 1'b1;
      ce_o   <= 1'b0;
      wen_o  <= 1'b1;
      oen_o  <= 1'b1;
      din_o  <= '0;
    end else begin
      addr_o <= addr_i;
      csn_o  <= csn_i;
      ce_o   <= ce_i;
      wen_o  <= wen_i;
      oen_o  <= oen_i;
      din_o  <= din_i;
    end
  end
endmodule

// File: rtl/dsram_ctrl.sv
module dsram_ctrl
  import dsram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] s_addr_i,
  input  logic              s_csn_i,
  input  logic              s_ce_i,
  input  logic              s_wen_i,
  input  logic              s_oen_i,
  input  logic [DATA_W-1:0] s_din_i,
  output logic              wr_commit_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  mode_e mode;
  logic  win, win_q;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;

  assign mode = decode_mode(s_csn_i, s_ce_i, s_wen_i, s_oen_i);
  assign win  = (mode == MODE_WRITE);

  // capture while open; last capture survives the close
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q     <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else begin
      win_q <= win;
      if (win) begin
        hold_addr <= s_addr_i;
        hold_data <= s_din_i;
      end
    end
  end

  assign wr_commit_o = win_q && !win;
  assign wr_addr_o   = hold_addr;
  assign wr_data_o   = hold_data;
  assign rd_en_o     = (mode == MODE_READ);
  assign rd_addr_o   = s_addr_i;
endmodule

// File: rtl/dsram_array.sv
module dsram_array #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter bit RD_BYPASS = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              oe_o
);
  localparam int Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [Depth];
  logic [DATA_W-1:0] rd_word;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  generate
    if (RD_BYPASS) begin : g_byp
      assign rd_word = (we_i && (waddr_i == raddr_i)) ? wdata_i : mem[raddr_i];
    end else begin : g_nobyp
      assign rd_word = mem[raddr_i];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      oe_o    <= 1'b0;
    end else begin
      rdata_o <= re_i ? rd_word : '0;
      oe_o    <= re_i;
    end
  end
endmodule

// File: rtl/dsram_top.sv
module dsram_top #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              csn_i,
  input  logic              ce_i,
  input  logic              wen_i,
  input  logic              oen_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic [ADDR_W-1:0] s_addr;
  logic              s_csn, s_ce, s_wen, s_oen;
  logic [DATA_W-1:0] s_din;
  logic              wr_commit, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data;

  dsram_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .csn_i  (csn_i),
    .ce_i   (ce_i),
    .wen_i  (wen_i),
    .oen_i  (oen_i),
    .din_i  (dq_i),
    .addr_o (s_addr),
    .csn_o  (s_csn),
    .ce_o   (s_ce),
    .wen_o  (s_wen),
    .oen_o  (s_oen),
    .din_o  (s_din)
  );

  dsram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .s_addr_i    (s_addr),
    .s_csn_i     (s_csn),
    .s_ce_i      (s_ce),
    .s_wen_i     (s_wen),
    .s_oen_i     (s_oen),
    .s_din_i     (s_din),
    .wr_commit_o (wr_commit),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .rd_en_o     (rd_en),
    .rd_addr_o   (rd_addr)
  );

  dsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_BYPASS(1'b1)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_commit),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .re_i    (rd_en),
    .raddr_i (rd_addr),
    .rdata_o (dq_o),
    .oe_o    (dq_oe_o)
  );
endmodule

// File: rtl/dsram_checker.sv
module dsram_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csn_i,
  input logic              ce_i,
  input logic              wen_i,
  input logic              oen_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe_o
);
  a_r2_csn_high_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(csn_i, 2) |-> !dq_oe_o);

  a_r3_ce_low_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ce_i, 2) |-> !dq_oe_o);

  a_r5_write_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wen_i, 2) |-> !dq_oe_o);

  a_r6_oen_high_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(oen_i, 2) |-> !dq_oe_o);

  // R4: a drive implies a full read pin state two edges earlier
  a_r4_drive_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (!$past(csn_i, 2) && $past(ce_i, 2) && $past(wen_i, 2) && !$past(oen_i, 2)));

  // R11
  a_r11_reset_quiet: assert property (@(posedge clk_i) !rst_ni |-> (!dq_oe_o && dq_o == '0));
endmodule

bind dsram_top dsram_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .csn_i   (csn_i),
  .ce_i    (ce_i),
  .wen_i   (wen_i),
  .oen_i   (oen_i),
  .dq_o    (dq_o),
  .dq_oe_o (dq_oe_o)
);

// File: tb/sim_dsram_top.sv
module sim_dsram_top;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam int MAXA = (1 << AW) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          csn_i = 1'b1, ce_i = 1'b0, wen_i = 1'b1, oen_i = 1'b1;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [DW-1:0] model [1 << AW];

  always #2 clk_i = ~clk_i;

  dsram_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic csn, ce, wen, oen, input int a, input int d);
    csn_i = csn; ce_i = ce; wen_i = wen; oen_i = oen;
    addr_i = AW'(a); dq_i = DW'(d);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // close kind: 0 raise wen, 1 raise csn, 2 drop ce
  task automatic wr(input int a, input int d, input int kind);
    drive(0, 1, 0, 1, a, d);
    step(2);
    case (kind)
      0: drive(0, 1, 1, 1, a, d);
      1: drive(1, 1, 0, 1, a, d);
      default: drive(0, 0, 0, 1, a, d);
    endcase
    step(2);
    drive(1, 0, 1, 1, 0, 0);
    model[a] = DW'(d);
  endtask

  task automatic rd_chk(input int a, input string req);
    drive(0, 1, 1, 0, a, 0);
    step(2);
    chk(dq_oe_o === 1'b1, req, dq_oe_o, 1);
    chk(dq_o === model[a], req, dq_o, model[a]);
    drive(1, 0, 1, 1, 0, 0);
    step(1);
  endtask

  task automatic quiet_chk(input string req);
    chk(dq_oe_o === 1'b0 && dq_o === '0, req, {dq_oe_o, dq_o}, 0);
  endtask

  task automatic t_reset;
    quiet_chk("R11 during reset");
    rst_ni = 1'b1;
    step(3);
    quiet_chk("R11 after reset");
  endtask

  task automatic t_fill;
    wr(0, 8'h3c, 0);
    wr(MAXA, 8'hc5, 1);
    wr(16'h0a55, 8'h5a, 2);
    wr(7, 8'h81, 0);
    rd_chk(0, "R1 addr 0 / R7 wen close");
    rd_chk(MAXA, "R1 top addr / R7 csn close");
    rd_chk(16'h0a55, "R7 ce close");
    rd_chk(7, "R1 mid addr");
  endtask

  task automatic t_desel;
    drive(1, 1, 1, 0, 7, 0); step(2); quiet_chk("R2 csn high read pins");
    drive(0, 0, 1, 0, 7, 0); step(2); quiet_chk("R3 ce low read pins");
    drive(1, 1, 0, 0, 7, 8'hee); step(3);
    drive(0, 0, 0, 0, 7, 8'hdd); step(3);
    drive(1, 0, 1, 1, 0, 0); step(2);
    rd_chk(7, "R2/R3 blocked write keeps word");
  endtask

  task automatic t_odis;
    drive(0, 1, 1, 1, 0, 8'h11); step(2); quiet_chk("R6 output disable");
    repeat (5) begin
      drive(0, 1, 1, 1, MAXA, 8'h22); step(1);
      drive(1, 1, 0, 0, MAXA, 8'h33); step(1);
    end
    drive(1, 0, 1, 1, 0, 0); step(2);
    rd_chk(MAXA, "R10 preserved across disable/deselect");
    rd_chk(0, "R6 no access under disable");
  endtask

  task automatic t_write_nodrive;
    drive(0, 1, 0, 0, 100, 8'h6b); step(2);
    quiet_chk("R5 oen low during write");
    drive(0, 1, 1, 1, 100, 8'h6b); step(2);
    drive(1, 0, 1, 1, 0, 0);
    model[100] = 8'h6b;
    rd_chk(100, "R5 write with oen low");
  endtask

  task automatic t_final;
    wr(200, 8'h01, 0);
    wr(201, 8'h02, 0);
    drive(0, 1, 0, 1, 200, 8'h90); step(1);
    drive(0, 1, 0, 1, 200, 8'h91); step(1);
    drive(0, 1, 0, 1, 201, 8'h92); step(2);
    drive(0, 1, 1, 1, 201, 8'h92); step(2);
    drive(1, 0, 1, 1, 0, 0);
    model[201] = 8'h92;
    rd_chk(201, "R8 last captured stored");
    rd_chk(200, "R8 earlier addr untouched");
  endtask

  task automatic t_follow;
    int seq [6] = '{0, 7, 100, MAXA, 201, 16'h0a55};
    for (int k = 0; k < 8; k++) begin
      if (k < 6) drive(0, 1, 1, 0, seq[k], 0);
      else drive(1, 0, 1, 1, 0, 0);
      if (k >= 2) begin
        chk(dq_oe_o === 1'b1 && dq_o === model[seq[k-2]], "R4 address follow",
            {dq_oe_o, dq_o}, {1'b1, model[seq[k-2]]});
      end
      step(1);
    end
    step(1);
  endtask

  task automatic t_collide;
    drive(0, 1, 0, 0, 300, 8'h4d); step(2);
    drive(0, 1, 1, 0, 300, 8'h4d); step(2);
    model[300] = 8'h4d;
    chk(dq_oe_o === 1'b1 && dq_o === 8'h4d, "R9 same-addr collision", {dq_oe_o, dq_o}, 9'h14d);
    drive(1, 0, 1, 1, 0, 0); step(1);
    drive(0, 1, 0, 0, 301, 8'hb2); step(2);
    drive(0, 1, 1, 0, 7, 8'hb2); step(2);
    model[301] = 8'hb2;
    chk(dq_oe_o === 1'b1 && dq_o === model[7], "R9 diff-addr collision", {dq_oe_o, dq_o}, {1'b1, model[7]});
    drive(1, 0, 1, 1, 0, 0); step(1);
    rd_chk(301, "R9 collided write stored");
  endtask

  initial begin
    step(2);
    t_reset();
    t_fill();
    t_desel();
    t_odis();
    t_write_nodrive();
    t_final();
    t_follow();
    t_collide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule